// File: doc/BRIEF.md
# External Interrupt Line Conditioner

This block sits between three external interrupt pins and a downstream interrupt controller that only understands two forms of request: an active-high level and a rising-edge pulse. Each pin is brought into the clock domain through a synchronizer. It is then qualified by its own control field, which selects one of four trigger kinds: high level, low level, rising edge or falling edge. The block turns each kind into one of the two forms the controller accepts. A low level is inverted into a high level. Both edge kinds become a single-cycle pulse, and the pulse also sets a sticky pending bit that software must clear.

Software programs the three control fields over a simple register bus. The bus has a combinational read path and writes that take effect on the clock edge. A parameter chooses the register layout. In the packed layout all three fields live in one 32-bit word, and byte enables let one field be updated without disturbing the others. In the split layout every line has its own word at a fixed offset. Each field also holds an enable bit that masks its line, and a clock-select bit that software can store and read back.

Top module: `ext_irq_conditioner`

## Requirements
- R1: Each line owns an 8-bit control field laid out as: bits 7:6 trigger kind (00 high level, 01 low level, 10 rising edge, 11 falling edge), bit 5 enable, bit 4 clock select (stored, read back, no other effect), bits 3:1 always read 0, bit 0 pending.
- R2: For a high-level line, the output equals enable AND the pin, seen through a two-flop synchronizer, so a pin change shows at the output after the second rising clock edge.
- R3: For a low-level line, the output equals enable AND the inverted synchronized pin, with the same latency as R2.
- R4: For a rising-edge line, a 0-to-1 change of the synchronized pin sets pending and drives a one-cycle output pulse, both visible after the third clock edge following the pin change.
- R5: For a falling-edge line, a 1-to-0 change of the synchronized pin gives the same one-cycle rising pulse and pending set as R4.
- R6: Pending stays set until a write with bit 0 = 1 lands on that field. Writing 0 to bit 0 leaves it unchanged, and an edge in the same cycle as a clear leaves it set.
- R7: A pulse is produced only when pending goes from 0 to 1. An edge that arrives while pending is already set produces no pulse.
- R8: With enable at 0, the line output stays 0 and edges do not set pending.
- R9: In the packed layout (SHARED_WORD=1) the word at offset 0x000 holds line 0 in bits 23:16, line 1 in 15:8 and line 2 in 7:0, and bits 31:24 read 0. Byte enable n gates bits 8n+7:8n, and every other address reads 0.
- R10: In the split layout (SHARED_WORD=0) lines 0, 1 and 2 sit at offsets 0x000, 0x328 and 0x32C with the field in bits 7:0, written under byte enable 0. Bits 31:8 read 0, and unmapped addresses read 0.
- R11: After reset every field is 0 (high level, disabled, nothing pending) and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 3 | Asynchronous external interrupt pins, bit i is line i |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 3 | Normalized requests: high level or one-cycle rising pulse |

## Verification
Both register layouts are instantiated side by side and driven with the same random pin toggles and random writes, including writes to unmapped addresses and with partial byte enables. A cycle model predicts every output and every read word. Toggling pins under all four trigger kinds separates correct polarity and edge-direction handling from swapped or inverted selection. Random byte enables on the packed word show whether one field's write leaks into a neighbour. Directed sequences time a clear to land in the same cycle as a new edge, send a second edge while pending is set, and toggle a masked line. These tell apart a sticky pending bit from one that re-arms, and a masked line from one that only hides its output.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

   typedef enum logic [1:0] {
      TRIG_HIGH = 2'b00,
      TRIG_LOW  = 2'b01,
      TRIG_RISE = 2'b10,
      TRIG_FALL = 2'b11
   } trig_e;

   localparam int BIT_PEND = 0;
   localparam int BIT_CSEL = 4;
   localparam int BIT_EN   = 5;
   localparam int TRIG_LSB = 6;

   typedef struct packed {
      trig_e trig;
      logic  en;
      logic  csel;
      logic  pend;
   } line_ctl_t;

   function automatic logic [7:0] pack_field(line_ctl_t c);
      return {c.trig, c.en, c.csel, 3'b000, c.pend};
   endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("eirq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/eirq_line.sv
module eirq_line
   import eirq_pkg::*;
#(
   parameter int FIELD_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pin_s,
   input  logic               wr_stb,
   input  logic [FIELD_W-1:0] wr_byte,
   output logic [FIELD_W-1:0] field_q,
   output logic               irq_o
);
   if (FIELD_W != 8) begin : g_bad_field
      $error("eirq_line: FIELD_W must be 8");
   end

   line_ctl_t ctl_q;
   logic      prev_q;
   logic      pulse_q;
   logic      rise, fall, evt, clr, edge_mode, lvl;
   logic      unused_wr;

   assign unused_wr = ^wr_byte[3:1];

   assign rise      = pin_s & ~prev_q;
   assign fall      = ~pin_s & prev_q;
   assign edge_mode = ctl_q.trig[1];
   assign lvl       = pin_s ^ (ctl_q.trig == TRIG_LOW);
   assign clr       = wr_stb & wr_byte[BIT_PEND];

   always_comb begin
      unique case (ctl_q.trig)
         TRIG_RISE: evt = ctl_q.en & rise;
         TRIG_FALL: evt = ctl_q.en & fall;
         default:   evt = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         prev_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         prev_q     <= pin_s;
         pulse_q    <= evt & ~ctl_q.pend;
         ctl_q.pend <= (ctl_q.pend & ~clr) | evt;
         if (wr_stb) begin
            ctl_q.trig <= trig_e'(wr_byte[TRIG_LSB +: 2]);
            ctl_q.en   <= wr_byte[BIT_EN];
            ctl_q.csel <= wr_byte[BIT_CSEL];
         end
      end
   end

   assign field_q = pack_field(ctl_q);
   assign irq_o   = ctl_q.en & (edge_mode ? pulse_q : lvl);

   // R8
   masked_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_q.pend) |-> $past(ctl_q.en));
   // R6
   pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.pend && !clr) |=> ctl_q.pend);
   // R7
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);
   // R4
   pulse_on_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> $rose(ctl_q.pend));
   // R1
   field_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      field_q[3:1] == 3'b000);
endmodule

// File: rtl/ext_irq_conditioner.sv
module ext_irq_conditioner
   import eirq_pkg::*;
#(
   parameter int                NUM_LINES   = 3,
   parameter int                DATA_W      = 32,
   parameter int                FIELD_W     = 8,
   parameter int                ADDR_W      = 12,
   parameter int                SYNC_STAGES = 2,
   parameter bit                SHARED_WORD = 1'b1,
   parameter logic [ADDR_W-1:0] OFS_LINE0   = 'h000,
   parameter logic [ADDR_W-1:0] OFS_LINE1   = 'h328,
   parameter logic [ADDR_W-1:0] OFS_LINE2   = 'h32C
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] ext_pin,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic [DATA_W/8-1:0]  bus_be,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic [NUM_LINES-1:0] irq_out
);
   localparam int BE_W = DATA_W / 8;
   localparam logic [ADDR_W-1:0] LINE_OFS [3] = '{OFS_LINE0, OFS_LINE1, OFS_LINE2};

   if (NUM_LINES != 3) begin : g_bad_lines
      $error("ext_irq_conditioner: exactly three lines are supported");
   end
   if (DATA_W != 32 || FIELD_W != 8) begin : g_bad_width
      $error("ext_irq_conditioner: DATA_W must be 32 and FIELD_W 8");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $error("ext_irq_conditioner: ADDR_W too small for line offsets");
   end

   logic [NUM_LINES-1:0] pin_s;
   logic [NUM_LINES-1:0] wr_stb;
   logic [FIELD_W-1:0]   wr_byte [NUM_LINES];
   logic [FIELD_W-1:0]   field   [NUM_LINES];
   logic                 unused_bus;

   assign unused_bus = ^{bus_wdata, bus_be};

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      eirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (ext_pin[i]),
         .q     (pin_s[i])
      );

      if (SHARED_WORD) begin : g_wr_packed
         localparam int LANE = NUM_LINES - 1 - i;
         assign wr_stb[i]  = bus_wr && (bus_addr == OFS_LINE0) && bus_be[LANE];
         assign wr_byte[i] = bus_wdata[LANE*FIELD_W +: FIELD_W];
      end else begin : g_wr_split
         assign wr_stb[i]  = bus_wr && (bus_addr == LINE_OFS[i]) && bus_be[0];
         assign wr_byte[i] = bus_wdata[FIELD_W-1:0];
      end

      eirq_line #(.FIELD_W(FIELD_W)) u_line (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin_s   (pin_s[i]),
         .wr_stb  (wr_stb[i]),
         .wr_byte (wr_byte[i]),
         .field_q (field[i]),
         .irq_o   (irq_out[i])
      );
   end

   if (SHARED_WORD) begin : g_rd_packed
      always_comb begin
         bus_rdata = '0;
         if (bus_addr == OFS_LINE0) begin
            for (int i = 0; i < NUM_LINES; i++) begin
               bus_rdata[(NUM_LINES-1-i)*FIELD_W +: FIELD_W] = field[i];
            end
         end
      end
   end else begin : g_rd_split
      always_comb begin
         bus_rdata = '0;
         for (int i = 0; i < NUM_LINES; i++) begin
            if (bus_addr == LINE_OFS[i]) bus_rdata[FIELD_W-1:0] = field[i];
         end
      end
   end

   // R11
   reset_quiet_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (irq_out == '0));
   // R9
   top_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1 -: 8] == 8'h00);
   // R8
   masked_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb[0] || field[0][BIT_EN]) |=> !irq_out[0]);
   initial begin
      be_width_chk: assert (BE_W * 8 == DATA_W);
   end
endmodule

// File: tb/ext_irq_conditioner_tb.sv
`timescale 1ns/1ps
module ext_irq_conditioner_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  ext_pin = '0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rd_pk, rd_sp;
   logic [2:0]  irq_pk, irq_sp;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   bit run_chk = 0;

   always #5 clk = ~clk;

   ext_irq_conditioner #(.SHARED_WORD(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(rd_pk), .irq_out(irq_pk));

   ext_irq_conditioner #(.SHARED_WORD(1'b0)) u_dut_sep (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(rd_sp), .irq_out(irq_sp));

   localparam logic [11:0] OFS [3] = '{12'h000, 12'h328, 12'h32C};

   // reference model: index 0 packed layout, index 1 split layout
   logic [7:0] mf [2][3];
   logic       mp [2][3];
   logic [2:0] m_s1, m_s2, m_pv;

   function automatic logic wr_hit(int m, int l);
      if (m == 0) return bus_wr && bus_addr == 12'h000 && bus_be[2-l];
      return bus_wr && bus_addr == OFS[l] && bus_be[0];
   endfunction

   function automatic logic [7:0] wr_val(int m, int l);
      if (m == 0) return bus_wdata[(2-l)*8 +: 8];
      return bus_wdata[7:0];
   endfunction

   function automatic logic exp_irq(int m, int l);
      logic [7:0] f = mf[m][l];
      if (!f[5]) return 1'b0;
      if (f[7]) return mp[m][l];
      return m_s2[l] ^ (f[7:6] == 2'b01);
   endfunction

   function automatic logic [31:0] exp_rd(int m);
      if (m == 0) return (bus_addr == 12'h000) ? {8'h00, mf[0][0], mf[0][1], mf[0][2]} : 32'h0;
      for (int l = 0; l < 3; l++) if (bus_addr == OFS[l]) return {24'h0, mf[1][l]};
      return 32'h0;
   endfunction

   function automatic string irq_tag(logic [1:0] t);
      case (t)
         2'b00: return "R2";
         2'b01: return "R3";
         2'b10: return "R4";
         default: return "R5";
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_pv = '0;
         for (int m = 0; m < 2; m++)
            for (int l = 0; l < 3; l++) begin mf[m][l] = '0; mp[m][l] = 1'b0; end
      end else begin
         for (int m = 0; m < 2; m++)
            for (int l = 0; l < 3; l++) begin
               logic [7:0] f;
               logic ev, hit, np;
               logic [7:0] wb;
               f   = mf[m][l];
               ev  = f[5] && ((f[7:6] == 2'b10 && m_s2[l] && !m_pv[l]) ||
                              (f[7:6] == 2'b11 && !m_s2[l] && m_pv[l]));
               hit = wr_hit(m, l);
               wb  = wr_val(m, l);
               np  = (f[0] & ~(hit & wb[0])) | ev;
               mp[m][l] = ev & ~f[0];
               mf[m][l] = hit ? {wb[7:4], 3'b000, np} : {f[7:1], np};
            end
         m_pv = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && run_chk && !done) begin
         for (int l = 0; l < 3; l++) begin
            chk(irq_tag(mf[0][l][7:6]), 32'(irq_pk[l]), 32'(exp_irq(0, l)));
            chk(irq_tag(mf[1][l][7:6]), 32'(irq_sp[l]), 32'(exp_irq(1, l)));
         end
         chk("R9", rd_pk, exp_rd(0));
         chk("R10", rd_sp, exp_rd(1));
      end
   end

   task automatic tick();
      @(posedge clk); #2;
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
      bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
      tick();
      bus_wr = 1'b0; bus_addr = 12'h000;
   endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #500us;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'hC0FFEE));
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R11: reset state
      @(negedge clk);
      chk("R11", rd_pk, 32'h0);
      chk("R11", rd_sp, 32'h0);
      chk("R11", {26'h0, irq_pk, irq_sp}, 32'h0);
      run_chk = 1;
      tick();

      // R1: all-ones write, bits 3:1 and pending clear read back as zero
      bus_write(12'h000, 4'hF, 32'hFFFF_FFFF);
      @(negedge clk);
      chk("R1", rd_pk, 32'h00F0_F0F0);
      chk("R1", rd_sp, 32'h0000_00F0);
      tick();

      // line 0 rising edge, enabled (lanes 2 and 0 carry the same byte)
      bus_write(12'h000, 4'b0101, 32'h00A0_00A0);
      ext_pin[0] = 1'b1;
      tick();
      tick();
      // clear lands in the same cycle as the edge
      bus_write(12'h000, 4'b0100, 32'h00A1_0000);
      @(negedge clk);
      chk("R6", 32'(rd_pk[23:16]), 32'hA1);
      chk("R4", 32'(irq_pk[0]), 32'h1);
      tick();
      @(negedge clk);
      chk("R7", 32'(irq_pk[0]), 32'h0);
      // second edge while pending is set: no pulse
      ext_pin[0] = 1'b0; tick(); tick();
      ext_pin[0] = 1'b1;
      for (int k = 0; k < 5; k++) begin
         tick();
         @(negedge clk);
         chk("R7", 32'(irq_pk[0]), 32'h0);
      end
      // writing 0 to pending keeps it; writing 1 clears it
      bus_write(12'h000, 4'b0100, 32'h00A0_0000);
      @(negedge clk);
      chk("R6", 32'(rd_pk[23:16]), 32'hA1);
      tick();
      bus_write(12'h000, 4'b0100, 32'h00A1_0000);
      @(negedge clk);
      chk("R6", 32'(rd_pk[23:16]), 32'hA0);
      tick();

      // masked rising-edge line: no output, no pending
      bus_write(12'h000, 4'b0100, 32'h0080_0000);
      ext_pin[0] = 1'b0; tick(); tick(); tick();
      ext_pin[0] = 1'b1;
      for (int k = 0; k < 5; k++) begin
         tick();
         @(negedge clk);
         chk("R8", 32'(irq_pk[0]), 32'h0);
      end
      chk("R8", 32'(rd_pk[23:16]), 32'h80);

      // constrained random phase
      for (int c = 0; c < 6000; c++) begin
         for (int l = 0; l < 3; l++)
            if ($urandom_range(5) == 0) ext_pin[l] = ~ext_pin[l];
         case ($urandom_range(3))
            0: bus_addr = 12'h000;
            1: bus_addr = 12'h328;
            2: bus_addr = 12'h32C;
            default: bus_addr = 12'h004;
         endcase
         bus_wr    = ($urandom_range(9) == 0);
         bus_be    = 4'($urandom);
         bus_wdata = $urandom | 32'h2020_2020;
         tick();
      end
      bus_wr = 1'b0;
      tick();
      finish_run();
   end
endmodule